// File: doc/BRIEF.md
# Loop Overshoot Peak Capture

This block records the largest phase overcorrection a frequency-synthesis loop makes after a deliberate phase step. At each reference edge (`ref_tick`), it reads the running count of the feedback divider. That count is the phase error in oscillator cycles. The block folds the count into an error magnitude relative to the divisor. It keeps a running maximum of that magnitude, but only once the crossover detector has seen the error change sign. Samples taken before the overshoot are therefore never recorded.

A capture starts with a one-cycle `start` pulse. The pulse clears the result and opens a window of a programmable number of reference ticks. When the window closes, `done` rises and the held maximum is frozen until the next start. The result grows with the injected step size, and a larger value points to more peaking in the loop. It is only meaningful when the static phase error of the loop is smaller than the overshoot.

Top module: `ovs_capture`

## Requirements
- R1: After reset, `max_ovs` is 0 and `done` is 0, and no capture is running.
- R2: A `start` pulse clears `max_ovs` to 0 and `done` to 0 on the next cycle and opens a new capture window.
- R3: For a sampled count c (assumed below divisor N), the error magnitude is c when c <= floor(N/2), and N - c otherwise.
- R4: The held maximum can change only on a `ref_tick` cycle inside an open window while `cross_seen` is 1. Samples taken while `cross_seen` is 0 are ignored.
- R5: The held maximum is replaced only when the new magnitude is strictly greater than it, so it never decreases during a capture.
- R6: `done` rises on the cycle after the `ref_tick` that completes `win_len` ticks (a `win_len` of 0 acts as 1). That tick is still sampled. `done` and `max_ovs` then hold until the next `start`.
- R7: When `start` and `ref_tick` occur in the same cycle, `start` wins: the tick is neither counted nor sampled.
- R8: A sample accepted at a clock edge appears on `max_ovs` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe at each reference edge |
| fb_count | input | CNT_W | Running count of the feedback divider |
| divisor | input | CNT_W | Feedback divisor N |
| start | input | 1 | Starts a capture and clears the result |
| cross_seen | input | 1 | High once the phase error has changed sign |
| win_len | input | WIN_W | Capture window length in reference ticks |
| max_ovs | output | CNT_W | Largest overshoot magnitude seen |
| done | output | 1 | Capture window has closed |

## Verification
A wrong window count shows up at `done`. It rises one or more ticks early or late, and the late case lets extra samples raise `max_ovs` after the window should have closed. A fold or compare fault shows on `max_ovs` on the cycle after the offending tick: a value too large, a value equal to the old one, or a value that drops. The bench compares both outputs against a behavioural model on every cycle, so any such fault is reported on the cycle it first appears.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;
endpackage

// File: rtl/ovs_phase_fold.sv
module ovs_phase_fold #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] divisor_i,
    output logic [CNT_W-1:0] mag_o
);
    logic [CNT_W-1:0] half;

    always_comb begin
        half = divisor_i >> 1;
        // counts past half a period are a lead of (N - c) cycles
        if (count_i > half) begin
            mag_o = divisor_i - count_i;
        end else begin
            mag_o = count_i;
        end
    end
endmodule

// File: rtl/ovs_window_ctr.sv
module ovs_window_ctr
    import ovs_pkg::*;
#(
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             accept_o,
    output logic             done_o
);
    typedef struct packed {
        win_state_e       st;
        logic [WIN_W-1:0] cnt;
        logic             done;
    } win_t;

    win_t s_d, s_q;
    logic [WIN_W:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        cnt_next = {1'b0, s_q.cnt} + 1'b1;
        accept_o = 1'b0;
        if (start_i) begin
            s_d.st   = WIN_RUN;
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (s_q.st == WIN_RUN && tick_i) begin
            accept_o = 1'b1;
            s_d.cnt  = cnt_next[WIN_W-1:0];
            if (cnt_next >= {1'b0, win_len_i}) begin
                s_d.st   = WIN_IDLE;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: WIN_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
endmodule

// File: rtl/ovs_peak_hold.sv
module ovs_peak_hold #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             upd_i,
    input  logic [CNT_W-1:0] mag_i,
    output logic [CNT_W-1:0] peak_o
);
    logic [CNT_W-1:0] peak_d, peak_q;

    always_comb begin
        peak_d = peak_q;
        if (clear_i) begin
            peak_d = '0;
        end else if (upd_i && (mag_i > peak_q)) begin
            peak_d = mag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else begin
            peak_q <= peak_d;
        end
    end

    assign peak_o = peak_q;
endmodule

// File: rtl/ovs_capture.sv
module ovs_capture #(
    parameter int CNT_W = 6,
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] fb_count,
    input  logic [CNT_W-1:0] divisor,
    input  logic             start,
    input  logic             cross_seen,
    input  logic [WIN_W-1:0] win_len,
    output logic [CNT_W-1:0] max_ovs,
    output logic             done
);
    logic             accept;
    logic [CNT_W-1:0] mag;

    ovs_window_ctr #(.WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .tick_i    (ref_tick),
        .win_len_i (win_len),
        .accept_o  (accept),
        .done_o    (done)
    );

    ovs_phase_fold #(.CNT_W(CNT_W)) u_fold (
        .count_i   (fb_count),
        .divisor_i (divisor),
        .mag_o     (mag)
    );

    ovs_peak_hold #(.CNT_W(CNT_W)) u_peak (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .upd_i   (accept & cross_seen),
        .mag_i   (mag),
        .peak_o  (max_ovs)
    );
endmodule

// File: rtl/ovs_capture_chk.sv
module ovs_capture_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             start,
    input logic             cross_seen,
    input logic [CNT_W-1:0] max_ovs,
    input logic             done
);
    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (max_ovs == '0) && !done);

    p_need_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(ref_tick && cross_seen)) |=> $stable(max_ovs));

    p_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> max_ovs >= $past(max_ovs));

    p_done_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(max_ovs));

    p_done_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !ref_tick) |=> !done);
endmodule

bind ovs_capture ovs_capture_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/ovs_capture_tb_top.sv
module ovs_capture_tb_top;
    localparam int CNT_W = 6;
    localparam int WIN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_tick = 1'b0;
    logic [CNT_W-1:0] fb_count = '0;
    logic [CNT_W-1:0] divisor = 6'd8;
    logic             start = 1'b0;
    logic             cross_seen = 1'b0;
    logic [WIN_W-1:0] win_len = '0;
    logic [CNT_W-1:0] max_ovs;
    logic             done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural model
    int m_max = 0;
    int m_done = 0;
    int m_run = 0;
    int m_seen = 0;

    always #5 clk = ~clk;

    ovs_capture #(.CNT_W(CNT_W), .WIN_W(WIN_W)) dut_i (.*);

    function automatic int fold(int c, int n);
        return (c > n / 2) ? n - c : c;
    endfunction

    task automatic compare(string tag);
        checks++;
        if (max_ovs !== m_max[CNT_W-1:0]) begin
            errors++;
            $display("FAIL %s max_ovs actual=%0d expected=%0d", tag, max_ovs, m_max);
        end
        checks++;
        if (done !== m_done[0]) begin
            errors++;
            $display("FAIL %s done actual=%0d expected=%0d", tag, done, m_done);
        end
    endtask

    // drive one cycle (called at negedge), update model, compare next negedge
    task automatic step(bit tk, int cnt, bit cr, bit st, string tag);
        int lim;
        ref_tick = tk; fb_count = cnt[CNT_W-1:0]; cross_seen = cr; start = st;
        lim = (win_len == 0) ? 1 : int'(win_len);
        if (st) begin
            m_max = 0; m_done = 0; m_run = 1; m_seen = 0;
        end else if (m_run == 1 && tk) begin
            if (cr && fold(cnt, int'(divisor)) > m_max) m_max = fold(cnt, int'(divisor));
            m_seen++;
            if (m_seen >= lim) begin m_run = 0; m_done = 1; end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // pre-crossover samples ignored
        win_len = 10'd12;
        step(0, 0, 0, 1, "R2");
        step(1, 3, 0, 0, "R4");
        step(1, 4, 0, 0, "R4");
        step(0, 4, 1, 0, "R4");           // no tick
        // crossover seen, fold and max tracking, N=8
        step(1, 1, 1, 0, "R8");
        step(1, 2, 1, 0, "R3");
        step(1, 7, 1, 0, "R5");           // mag 1, smaller
        step(1, 6, 1, 0, "R5");           // mag 2, equal
        step(1, 5, 1, 0, "R3");           // mag 3
        step(1, 4, 1, 0, "R3");           // mag 4 at half
        step(1, 1, 1, 0, "R5");
        step(1, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R6");
        step(1, 0, 1, 0, "R6");
        step(1, 3, 1, 0, "R6");           // 12th tick closes window
        step(1, 4, 1, 0, "R6");           // after done, ignored
        step(0, 4, 1, 0, "R6");

        // restart clears, odd divisor N=9
        divisor = 6'd9; win_len = 10'd4;
        step(0, 0, 0, 1, "R2");
        step(1, 5, 1, 0, "R3");           // 9-5 = 4
        step(1, 4, 1, 0, "R3");           // 4, equal
        step(1, 6, 1, 0, "R5");
        step(1, 8, 1, 0, "R6");           // closes
        step(1, 4, 1, 0, "R6");

        // start with tick in same cycle: tick not counted
        win_len = 10'd1; divisor = 6'd16;
        step(1, 7, 1, 1, "R7");
        checks++;
        if (done !== 1'b0) begin
            errors++;
            $display("FAIL R7 done actual=%0d expected=0", done);
        end
        step(1, 6, 1, 0, "R7");

        // zero length window acts as one tick
        win_len = 10'd0;
        step(0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, "R6");
        step(1, 9, 1, 0, "R6");           // 16-9 = 7
        step(1, 8, 1, 0, "R6");

        // reset mid capture
        win_len = 10'd8;
        step(0, 0, 0, 1, "R2");
        step(1, 3, 1, 0, "R8");
        rst_n = 1'b0;
        m_max = 0; m_done = 0; m_run = 0; m_seen = 0;
        ref_tick = 1'b0; start = 1'b0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step(1, 3, 1, 0, "R1");           // idle: no capture

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule